// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus. It fronts a byte-wide storage array of 16,384 or 32,768 bytes, chosen by a parameter, and the array is split into 64-byte pages. A master addresses the slave with a select byte. That byte carries a fixed type code, two bits that must equal the two strap inputs, and a read/write flag, so four slaves can share one bus. A write transfer then sends a two-byte word address and any number of data bytes. Those bytes collect in a page buffer, and the array row is updated only when the master sends STOP.

Reads can start at the current address or at a random address. A random read is a dummy write of the address followed by a repeated START. A read can continue sequentially for as many bytes as the master acknowledges. After each committed write the slave stays busy for a parameterized number of clocks and ignores selection. A protect input blocks array updates.

The bus lines are sampled with the system clock. The data line is never driven high: the block asserts only a pull-low enable.

Top module: `ee_twowire_slave`

## Requirements
- R1: The select byte is 1010, then 0, then the two strap bits `dev_sel_i[1]` and `dev_sel_i[0]`, then R/W (1 = read), sent MSB first. A byte that does not match gets no acknowledge, and the rest of that transfer is ignored and does not change the array.
- R2: After a committed write, the slave does not acknowledge any select byte for `WR_CYCLES` clocks. After that time it acknowledges again.
- R3: Data bytes of a write land at consecutive addresses starting at the word address, and the array changes only at STOP. A partial page write changes only the bytes that were received.
- R4: During a write, the low 6 address bits wrap inside the current 64-byte page. A 65th or later byte overwrites the bytes from the start of that page.
- R5: With `wr_lock_i` high at STOP, a write transfer is still acknowledged byte by byte, but the array is unchanged and no busy period starts.
- R6: A random read (select write, two address bytes, repeated START, select read) returns the byte stored at that address.
- R7: A sequential read increments the full word address after each byte and rolls over from the last byte of the array to address 0.
- R8: When the master does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next START.
- R9: Word-address bits above the array's address width (the top 2 bits of the high byte for 16 KiB) are ignored.
- R10: The slave only pulls the data line low (a 0 bit or an acknowledge) and changes its pull only while the clock line is low. It is released after reset.
- R11: A current-address read (select read with no address phase) starts at the address that follows the last byte accessed.
- R12: A repeated START inside a write transfer discards the bytes received so far: no array update and no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| dev_sel_i | input | 2 | Strap bits matched against the select byte |
| wr_lock_i | input | 1 | Write protect, high blocks array updates |
| sda_pull_o | output | 1 | Open-drain enable, high pulls the data line low |

## Verification
The hardest case to reach from the ports is where the address pointer meets a boundary. It has to sit at an in-page wrap or at the end of the array while the rest of the array holds known data. The stimulus first fills a whole page and rewrites three bytes inside it. It then writes a burst that starts four bytes before a page end, and writes the last two bytes of the array and the first three bytes of address 0 as separate transfers. Sequential and current-address reads then cross exactly those boundaries. The busy window, the protect input and the write aborted by a repeated START are each checked by how the very next select byte is acknowledged.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int PAGE_BYTES = 64;
  localparam int OFS_W      = 6;
  localparam int ROW_W      = PAGE_BYTES * 8;
  localparam logic [3:0] SEL_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT, ST_RACK
  } ee_state_e;
endpackage

// File: rtl/ee_line_mon.sv
module ee_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
  parameter int CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)             cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ee_page_store.sv
module ee_page_store
  import ee_pkg::*;
#(
  parameter int MEM_BYTES = 16384
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          buf_clr,
  input  logic                          buf_we,
  input  logic [OFS_W-1:0]              buf_ofs,
  input  logic [7:0]                    buf_din,
  input  logic                          commit,
  input  logic [$clog2(MEM_BYTES)-7:0]  commit_page,
  input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
  output logic [7:0]                    rd_data,
  output logic                          buf_any
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int PAGES = MEM_BYTES / PAGE_BYTES;

  logic [ROW_W-1:0]      mem_q [PAGES];
  logic [ROW_W-1:0]      pbuf_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [ROW_W-1:0]      wmask;
  logic [ROW_W-1:0]      rd_row;
  logic [8:0]            wr_pos, rd_pos;

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_wmask
      assign wmask[g*8 +: 8] = {8{mask_q[g]}};
    end
  endgenerate

  assign wr_pos = {buf_ofs, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (buf_clr) begin
      mask_q <= '0;
    end else if (buf_we) begin
      mask_q[buf_ofs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[wr_pos +: 8] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (commit) mem_q[commit_page] <= (mem_q[commit_page] & ~wmask) | (pbuf_q & wmask);
  end

  assign rd_row  = mem_q[rd_addr[AW-1:OFS_W]];
  assign rd_pos  = {rd_addr[OFS_W-1:0], 3'b000};
  assign rd_data = rd_row[rd_pos +: 8];
  assign buf_any = |mask_q;
endmodule

// File: rtl/ee_twowire_slave.sv
module ee_twowire_slave
  import ee_pkg::*;
#(
  parameter int MEM_BYTES = 16384,
  parameter int WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel_i,
  input  logic       wr_lock_i,
  output logic       sda_pull_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = AW - OFS_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, buf_any, buf_clr, buf_we, commit, dev_hit;
  logic [7:0] rd_data;

  ee_state_e     st_q, st_d;
  logic [7:0]    sreg_q, sreg_d, txsh_q, txsh_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic          in_ack_q, in_ack_d, pull_q, pull_d, mack_q, mack_d;
  logic [AW-1:0] addr_q, addr_d;

  ee_line_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  ee_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy)
  );

  ee_page_store #(.MEM_BYTES(MEM_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_ofs(addr_q[OFS_W-1:0]), .buf_din(sreg_q), .commit(commit),
    .commit_page(addr_q[AW-1:OFS_W]), .rd_addr(addr_q), .rd_data(rd_data),
    .buf_any(buf_any)
  );

  assign dev_hit = (sreg_q[7:4] == SEL_TYPE) && !sreg_q[3] && (sreg_q[2:1] == dev_sel_i);

  always_comb begin
    st_d     = st_q;
    sreg_d   = sreg_q;
    txsh_d   = txsh_q;
    bitcnt_d = bitcnt_q;
    in_ack_d = in_ack_q;
    pull_d   = pull_q;
    mack_d   = mack_q;
    addr_d   = addr_q;
    buf_clr  = 1'b0;
    buf_we   = 1'b0;
    commit   = 1'b0;
    if (stop_det) begin
      commit   = (st_q == ST_WDAT) && buf_any && !wr_lock_i;
      st_d     = ST_IDLE;
      pull_d   = 1'b0;
      in_ack_d = 1'b0;
    end else if (start_det) begin
      st_d     = ST_DEV;
      bitcnt_d = '0;
      in_ack_d = 1'b0;
      pull_d   = 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !in_ack_q) begin
            sreg_d   = {sreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && in_ack_q) begin
            in_ack_d = 1'b0;
            pull_d   = 1'b0;
            bitcnt_d = '0;
            if (st_q == ST_DEV) begin
              if (sreg_q[0]) begin
                st_d   = ST_RDAT;
                txsh_d = rd_data;
                pull_d = ~rd_data[7];
              end else begin
                st_d = ST_AHI;
              end
            end else if (st_q == ST_AHI) begin
              st_d = ST_ALO;
            end else if (st_q == ST_ALO) begin
              st_d = ST_WDAT;
            end
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            in_ack_d = 1'b1;
            pull_d   = 1'b1;
            if (st_q == ST_DEV) begin
              if (!dev_hit || busy) begin
                st_d     = ST_IDLE;
                in_ack_d = 1'b0;
                pull_d   = 1'b0;
              end
            end else if (st_q == ST_AHI) begin
              addr_d[AW-1:8] = sreg_q[AW-9:0];
            end else if (st_q == ST_ALO) begin
              addr_d[7:0] = sreg_q;
              buf_clr     = 1'b1;
            end else begin
              buf_we               = 1'b1;
              addr_d[OFS_W-1:0]    = addr_q[OFS_W-1:0] + 6'd1;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              pull_d = 1'b0;
              st_d   = ST_RACK;
              addr_d = addr_q + AW'(1);
            end else begin
              txsh_d = {txsh_q[6:0], 1'b0};
              pull_d = ~txsh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d     = ST_RDAT;
              txsh_d   = rd_data;
              pull_d   = ~rd_data[7];
              bitcnt_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      sreg_q   <= '0;
      txsh_q   <= '0;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
      mack_q   <= 1'b0;
      addr_q   <= '0;
    end else begin
      st_q     <= st_d;
      sreg_q   <= sreg_d;
      txsh_q   <= txsh_d;
      bitcnt_q <= bitcnt_d;
      in_ack_q <= in_ack_d;
      pull_q   <= pull_d;
      mack_q   <= mack_d;
      addr_q   <= addr_d;
    end
  end

  assign sda_pull_o = pull_q;
endmodule

// File: rtl/ee_twowire_chk.sv
module ee_twowire_chk
  import ee_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_i,
  input logic      pull,
  input ee_state_e st,
  input logic      busy,
  input logic      commit,
  input logic      buf_any,
  input logic      wr_lock
);
  assert_pull_hold_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(pull));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !pull);

  assert_no_select_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_DEV) |-> !pull);

  assert_commit_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  assert_commit_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> buf_any);

  assert_busy_only_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wr_lock));
endmodule

bind ee_twowire_slave ee_twowire_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .pull(sda_pull_o), .st(st_q),
  .busy(busy), .commit(commit), .buf_any(buf_any), .wr_lock(wr_lock_i)
);

// File: tb/sim_ee_twowire_slave.sv
module sim_ee_twowire_slave;
  localparam int MEM_BYTES = 16384;
  localparam int WR_CYC    = 400;
  localparam int Q         = 8;
  localparam int AMASK     = MEM_BYTES - 1;

  logic       clk, rst_n, scl, m_low, wp;
  logic [1:0] pins;
  logic       sda_pull;
  wire        sda_bus = ~(m_low | sda_pull);

  int n_tests, n_fail;
  logic [7:0] model [int];
  bit done;

  ee_twowire_slave #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_sel_i(pins), .wr_lock_i(wp), .sda_pull_o(sda_pull)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; half(); scl = 1'b1; half(); m_low = 1'b1; half(); scl = 1'b0; half();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; half(); scl = 1'b1; half(); m_low = 1'b0; half();
  endtask

  task automatic clk_bit(input bit v, output bit seen);
    m_low = !v; half(); scl = 1'b1; half(); seen = sda_bus; half(); scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    chk((!s) == exp_ack, tag, int'(!s), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string tag);
    logic [7:0] got;
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      got[i] = s;
    end
    clk_bit(!mack, s);
    chk(got == exp, tag, int'(got), int'(exp));
  endtask

  function automatic logic [7:0] sel(input logic [1:0] p, input bit rd);
    return {4'b1010, 1'b0, p, rd};
  endfunction

  // raw: 16-bit word address as sent; model keeps only the array's bits
  task automatic write_seq(input int raw, input logic [7:0] q[$], input string tag);
    int a = raw & AMASK;
    i2c_start();
    send_byte(sel(pins, 1'b0), 1'b1, tag);
    send_byte(raw[15:8], 1'b1, tag);
    send_byte(raw[7:0], 1'b1, tag);
    foreach (q[k]) send_byte(q[k], 1'b1, tag);
    i2c_stop();
    if (!wp)
      foreach (q[k]) model[(a & ~63) | ((a + k) & 63)] = q[k];
  endtask

  task automatic read_seq(input int a, input int n, input string tag);
    i2c_start();
    send_byte(sel(pins, 1'b0), 1'b1, tag);
    send_byte(a[15:8], 1'b1, tag);
    send_byte(a[7:0], 1'b1, tag);
    i2c_start();
    send_byte(sel(pins, 1'b1), 1'b1, tag);
    for (int k = 0; k < n; k++)
      recv_byte(model[(a + k) & AMASK], k != n - 1, tag);
    half();
    chk(sda_pull == 1'b0, "R8 release after master nack", int'(sda_pull), 0);
    i2c_stop();
  endtask

  task automatic settle();
    repeat (WR_CYC + 40) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    n_tests = 0; n_fail = 0; done = 1'b0;
    scl = 1'b1; m_low = 1'b0; wp = 1'b0; pins = 2'b10; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R10 released in reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_pull == 1'b0, "R10 released after reset", int'(sda_pull), 0);

    // R9: high byte 0xC1 carries two unused bits, lands at 0x0123
    q = {8'h5A};
    write_seq(16'hC123, q, "R3 R9 byte write");
    // R2: select straight after STOP is refused
    i2c_start();
    send_byte(sel(pins, 1'b0), 1'b0, "R2 nack while busy");
    i2c_stop();
    settle();
    read_seq(16'h0123, 1, "R6 R9 random read");

    // R1: wrong straps, wrong type code; trailing bytes are ignored
    i2c_start();
    send_byte(sel(2'b01, 1'b0), 1'b0, "R1 strap mismatch");
    send_byte(8'h01, 1'b0, "R1 ignored addr");
    send_byte(8'h23, 1'b0, "R1 ignored addr");
    send_byte(8'h00, 1'b0, "R1 ignored data");
    i2c_stop();
    i2c_start();
    send_byte(8'hB4, 1'b0, "R1 type mismatch");
    i2c_stop();
    read_seq(16'h0123, 1, "R1 array unchanged");

    // R3: full page, then a partial rewrite of three bytes
    q = {};
    for (int k = 0; k < 64; k++) q.push_back(8'((k * 7 + 3) & 255));
    write_seq(16'h0240, q, "R3 full page");
    settle();
    q = {8'h11, 8'h22, 8'h33};
    write_seq(16'h0245, q, "R3 partial page");
    settle();
    read_seq(16'h0240, 64, "R3 page readback");

    // R4: 8 bytes from offset 60 wrap to offsets 0..3 of the same page
    q = {};
    for (int k = 0; k < 8; k++) q.push_back(8'(8'hC0 + k));
    write_seq(16'h03BC, q, "R4 wrap write");
    settle();
    read_seq(16'h03BC, 4, "R4 page tail");
    read_seq(16'h0380, 4, "R4 page head overwritten");

    // R5: protected write is acked, changes nothing, starts no busy time
    wp = 1'b1;
    q = {8'hEE};
    write_seq(16'h0123, q, "R5 protected write acked");
    wp = 1'b0;
    read_seq(16'h0123, 1, "R5 no busy, array unchanged");

    // R12: repeated START inside a write discards the data byte
    i2c_start();
    send_byte(sel(pins, 1'b0), 1'b1, "R12 select");
    send_byte(8'h01, 1'b1, "R12 addr");
    send_byte(8'h23, 1'b1, "R12 addr");
    send_byte(8'h77, 1'b1, "R12 data");
    read_seq(16'h0123, 1, "R12 aborted write");

    // R7: read across the end of the array into address 0
    q = {8'hA1, 8'hA2};
    write_seq(16'h3FFE, q, "R7 top bytes");
    settle();
    q = {8'hB0, 8'hB1, 8'hB2};
    write_seq(16'h0000, q, "R7 bottom bytes");
    settle();
    read_seq(16'h3FFE, 4, "R7 rollover read");

    // R11: current-address read continues at 0x0002
    i2c_start();
    send_byte(sel(pins, 1'b1), 1'b1, "R11 select read");
    recv_byte(model[2], 1'b0, "R11 current address");
    half();
    chk(sda_pull == 1'b0, "R8 release after nack", int'(sda_pull), 0);
    i2c_stop();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule